// File: doc/BRIEF.md
# Read-After-Write Stall Interlock

This block guards a five-stage in-order pipeline that has no bypass network. Each cycle it looks at the two source register names of the instruction sitting in decode. It compares them with the destination names of the instructions now in the execute and memory stages. When a source names a register that one of those older instructions will still write, the block freezes the program counter and the fetch/decode register. It also zeroes the control word entering execute, so that a bubble moves down the pipe in place of the stalled instruction.

The block holds no state. The stall stays high for as long as any match remains. As the producer moves from execute to memory and then to write-back, the match clears by itself. A producer one instruction ahead therefore costs two bubbles, and a producer two ahead costs one. An instruction in write-back never causes a stall: the register file writes in the first half of a cycle and reads in the second half.

Top module: `hz_stall_unit`

## Requirements
- R1: The stall (pc_hold, fd_hold and ex_flush all 1) is raised exactly when either decode source equals ex_dst with ex_wr high, or equals mem_dst with mem_wr high. In both cases the destination must be nonzero. In every other case all three outputs are 0.
- R2: A stage whose write flag is 0 never causes a stall, whatever its destination name holds.
- R3: Destination register 0 never causes a stall, even when its write flag is 1 and a source names register 0.
- R4: Both decode sources are compared. A match on dec_src_a alone, or on dec_src_b alone, is enough to stall.
- R5: pc_hold, fd_hold and ex_flush are always equal to each other.
- R6: In a pipeline that advances under this unit, a consumer directly behind its producer (no instructions between them) suffers exactly 2 bubbles. With one independent instruction between them it suffers 1 bubble. With two or more between them it suffers none, because the producer has reached write-back.
- R7: In a chain where each instruction reads the result of the one directly before it, each link adds 2 bubbles. A chain of three instructions costs 4 bubbles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_src_a | input | REG_W | First source register name of the decode-stage instruction |
| dec_src_b | input | REG_W | Second source register name of the decode-stage instruction |
| ex_dst | input | REG_W | Destination name of the instruction in execute |
| ex_wr | input | 1 | Register-write enable of the instruction in execute |
| mem_dst | input | REG_W | Destination name of the instruction in memory |
| mem_wr | input | 1 | Register-write enable of the instruction in memory |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| fd_hold | output | 1 | Keep the fetch/decode register unchanged this cycle |
| ex_flush | output | 1 | Zero the control word entering execute (insert a bubble) |

## Verification
The behaviour that is hardest to reach is the bubble count. No single input vector shows it. It only appears when the stall feeds back into a moving pipeline and the producer moves on stage by stage.

The bench surrounds the unit with its own small pipeline model. It runs short programs with zero, one, two and three independent instructions between producer and consumer, plus a three-instruction dependence chain. It then counts the bubbles inserted. The combinational rule itself is swept over every combination of names and write flags for a 3-bit register field.

// File: rtl/hz_stall_unit.sv
module hz_stall_unit #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wr,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  output logic             pc_hold,
  output logic             fd_hold,
  output logic             ex_flush
);

  localparam logic [REG_W-1:0] R_ZERO = '0;

  logic ex_live, mem_live;
  logic hit_ex, hit_mem, stall;

  assign ex_live  = ex_wr  && (ex_dst  != R_ZERO);
  assign mem_live = mem_wr && (mem_dst != R_ZERO);

  assign hit_ex  = ex_live  && ((dec_src_a == ex_dst)  || (dec_src_b == ex_dst));
  assign hit_mem = mem_live && ((dec_src_a == mem_dst) || (dec_src_b == mem_dst));

  assign stall    = hit_ex || hit_mem;
  assign pc_hold  = stall;
  assign fd_hold  = stall;
  assign ex_flush = stall;

endmodule

module hz_stall_chk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] dec_src_a,
  input logic [REG_W-1:0] dec_src_b,
  input logic [REG_W-1:0] ex_dst,
  input logic             ex_wr,
  input logic [REG_W-1:0] mem_dst,
  input logic             mem_wr,
  input logic             pc_hold,
  input logic             fd_hold,
  input logic             ex_flush
);

  always_comb begin
    if (ex_wr && ex_dst != '0 && dec_src_a == ex_dst)
      a_r4_src_a_ex: assert (pc_hold === 1'b1);
    if (ex_wr && ex_dst != '0 && dec_src_b == ex_dst)
      a_r4_src_b_ex: assert (pc_hold === 1'b1);
    if (mem_wr && mem_dst != '0 && (dec_src_a == mem_dst || dec_src_b == mem_dst))
      a_r1_mem_match: assert (fd_hold === 1'b1);
    if (ex_wr === 1'b0 && mem_wr === 1'b0)
      a_r2_no_writer: assert (pc_hold === 1'b0);
    if (ex_dst === '0 && mem_dst === '0)
      a_r3_zero_dest: assert (ex_flush === 1'b0);
    if (!$isunknown({dec_src_a, dec_src_b, ex_dst, ex_wr, mem_dst, mem_wr}))
      a_r5_outputs_agree: assert (pc_hold === fd_hold && fd_hold === ex_flush);
  end

endmodule

bind hz_stall_unit hz_stall_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/tb_hz_stall_unit.sv
module tb_hz_stall_unit;
  localparam int W = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;

  typedef struct packed {
    logic         we;
    logic [W-1:0] dst;
    logic [W-1:0] sa;
    logic [W-1:0] sb;
  } ins_t;

  logic         run, prst;
  logic [W-1:0] s_sa, s_sb, s_exd, s_memd;
  logic         s_exw, s_memw;

  ins_t prog [8];
  int   pc;
  logic fd_v, de_v, em_v;
  ins_t fd_i, de_i, em_i;
  int   bub;

  logic [W-1:0] dec_src_a, dec_src_b, ex_dst, mem_dst;
  logic         ex_wr, mem_wr, pc_hold, fd_hold, ex_flush;

  assign dec_src_a = run ? (fd_v ? fd_i.sa : '0) : s_sa;
  assign dec_src_b = run ? (fd_v ? fd_i.sb : '0) : s_sb;
  assign ex_dst    = run ? de_i.dst : s_exd;
  assign ex_wr     = run ? (de_v && de_i.we) : s_exw;
  assign mem_dst   = run ? em_i.dst : s_memd;
  assign mem_wr    = run ? (em_v && em_i.we) : s_memw;

  hz_stall_unit #(.REG_W(W)) dut (.*);

  always_ff @(posedge clk) begin
    if (prst) begin
      pc <= 0; fd_v <= 1'b0; de_v <= 1'b0; em_v <= 1'b0;
      fd_i <= '0; de_i <= '0; em_i <= '0; bub <= 0;
    end else begin
      em_v <= de_v; em_i <= de_i;
      if (pc_hold) begin
        de_v <= 1'b0; de_i <= '0; bub <= bub + 1;
      end else begin
        de_v <= fd_v; de_i <= fd_i;
        fd_v <= 1'b1; fd_i <= (pc < 8) ? prog[pc] : '0;
        pc <= pc + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic ins_t mk(input logic we, input int d, input int a, input int b);
    mk = '{we: we, dst: W'(d), sa: W'(a), sb: W'(b)};
  endfunction

  task automatic run_prog(input string req, input int exp);
    @(negedge clk); prst = 1'b1; run = 1'b1;
    @(negedge clk); prst = 1'b0;
    repeat (20) @(negedge clk);
    chk(req, bub, exp);
    for (int i = 0; i < 8; i++) prog[i] = '0;
  endtask

  initial begin
    #700000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    run = 1'b0; prst = 1'b1;
    s_sa = '0; s_sb = '0; s_exd = '0; s_memd = '0; s_exw = 1'b0; s_memw = 1'b0;
    for (int i = 0; i < 8; i++) prog[i] = '0;
    @(negedge clk);
    #1 chk("R1 idle", {pc_hold, fd_hold, ex_flush}, 0);

    for (int v = 0; v < (1 << (4*W + 2)); v++) begin
      @(negedge clk);
      {s_memw, s_exw, s_memd, s_exd, s_sb, s_sa} = (4*W + 2)'(v);
      #1;
      begin
        bit ea, eb, ma, mb, exp;
        ea = s_exw && s_exd != 0 && s_sa == s_exd;
        eb = s_exw && s_exd != 0 && s_sb == s_exd;
        ma = s_memw && s_memd != 0 && s_sa == s_memd;
        mb = s_memw && s_memd != 0 && s_sb == s_memd;
        exp = ea | eb | ma | mb;
        if (!s_exw && !s_memw) chk("R2 no writer", int'(pc_hold), 0);
        else if (s_exd == 0 && s_memd == 0) chk("R3 zero dest", int'(pc_hold), 0);
        else if ((ea | ma) != (eb | mb)) chk("R4 single source", int'(pc_hold), int'(exp));
        else chk("R1 sweep", int'(pc_hold), int'(exp));
        chk("R5 agree", {pc_hold, fd_hold, ex_flush}, exp ? 7 : 0);
      end
    end

    prog[0] = mk(1, 5, 1, 2); prog[1] = mk(1, 6, 3, 5);
    run_prog("R6 distance 1", 2);
    prog[0] = mk(1, 5, 1, 2); prog[1] = mk(1, 6, 5, 3);
    run_prog("R6 distance 1 src a", 2);
    prog[0] = mk(1, 5, 1, 2); prog[2] = mk(1, 6, 3, 5);
    run_prog("R6 distance 2", 1);
    prog[0] = mk(1, 5, 1, 2); prog[3] = mk(1, 6, 3, 5);
    run_prog("R6 distance 3", 0);
    prog[0] = mk(1, 5, 1, 2); prog[4] = mk(1, 6, 5, 5);
    run_prog("R6 distance 4", 0);
    prog[0] = mk(1, 5, 1, 2); prog[1] = mk(1, 6, 5, 1); prog[2] = mk(1, 7, 2, 6);
    run_prog("R7 chain", 4);
    prog[0] = mk(1, 0, 1, 2); prog[1] = mk(1, 6, 0, 0);
    run_prog("R3 pipeline r0", 0);
    prog[0] = mk(0, 5, 1, 2); prog[1] = mk(1, 6, 5, 5);
    run_prog("R2 pipeline no write", 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule